// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 16-bit virtual address into a physical address with a small segment table kept in flip-flops. The two top address bits pick one of four segment entries. Each entry holds a base, a limit, a valid flag and a store-permission flag. The lower 14 bits are the offset. The offset is checked against the entry, and if the access is legal it is added to the base. Otherwise the access reports a fault, with a code that tells which check failed.

A configuration port loads the segment entries. It takes effect only while the kernel-mode input is high. An attempt made in user mode leaves the table unchanged and raises a one-cycle denial flag. Each request carries a store flag. The result comes out one clock later, qualified by a response strobe.

Top module: `segxlat_top`

## Requirements
- R1: After reset, rsp_valid and cfg_denied are 0 and every segment entry is invalid, so any request faults with code 01.
- R2: Virtual bits 15:14 select the segment and bits 13:0 are the offset. A legal access returns base + offset modulo 2^16.
- R3: An offset strictly greater than the segment's limit faults with code 10. An offset equal to the limit is legal.
- R4: An access to a segment whose valid flag is clear faults with code 01.
- R5: A store (req_write=1) to a segment without store permission faults with code 11. Loads to such a segment are legal, and stores to a segment with permission are legal.
- R6: When several fault conditions hold, the reported code follows the priority invalid (01), then limit (10), then store protection (11). Code 00 means no fault.
- R7: A faulting response carries rsp_pa = 0.
- R8: rsp_valid is 1 exactly in the cycle after a cycle with req_valid = 1, and 0 otherwise.
- R9: A table write made with cfg_kernel = 1 applies to requests issued in later cycles. A request issued in the same cycle as the write sees the old entry.
- R10: A table write with cfg_kernel = 0 leaves the table unchanged, and cfg_denied is 1 in the following cycle. A kernel write leaves cfg_denied at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write request |
| cfg_kernel | input | 1 | Kernel mode; a table write is honoured only when this is high |
| cfg_idx | input | 2 | Segment entry to write |
| cfg_base | input | 16 | Physical base of the entry |
| cfg_limit | input | 14 | Largest legal offset |
| cfg_valid | input | 1 | Entry valid flag |
| cfg_writable | input | 1 | Entry permits stores |
| cfg_denied | output | 1 | Pulses the cycle after a user-mode write attempt |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 16 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_pa | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 invalid, 10 limit, 11 store protection |

## Verification
A request sampled at a rising edge yields its strobe, address and fault code right after that edge. The table write and the denial flag follow the same one-edge timing. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. The same-cycle write-and-request case checks the old entry on that falling edge and the new entry on the request that follows.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;
    localparam int VA_W  = 16;
    localparam int SEG_W = 2;
    localparam int OFF_W = VA_W - SEG_W;
    localparam int PA_W  = 16;
    localparam int NSEG  = 1 << SEG_W;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_INVALID = 2'b01,
        FLT_LIMIT   = 2'b10,
        FLT_WPROT   = 2'b11
    } fault_e;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] limit;
        logic             valid;
        logic             writable;
    } seg_entry_t;

    typedef struct packed {
        fault_e          fault;
        logic [PA_W-1:0] pa;
    } xlat_res_t;

    // Priority: invalid, then limit, then store protection
    function automatic fault_e judge(seg_entry_t e, logic [OFF_W-1:0] off, logic wr);
        if (!e.valid)                 return FLT_INVALID;
        else if (off > e.limit)       return FLT_LIMIT;
        else if (wr && !e.writable)   return FLT_WPROT;
        else                          return FLT_NONE;
    endfunction

    function automatic logic [PA_W-1:0] relocate(logic [PA_W-1:0] base, logic [OFF_W-1:0] off);
        return base + PA_W'(off);
    endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
    import segxlat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic                  kernel,
    input  logic [SEG_W-1:0]      idx,
    input  seg_entry_t            wdata,
    output seg_entry_t [NSEG-1:0] tbl,
    output logic                  denied
);
    logic [NSEG-1:0] vmask;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl    <= '0;
            denied <= 1'b0;
        end else begin
            denied <= we && !kernel;
            for (int i = 0; i < NSEG; i++) begin
                if (we && kernel && idx == SEG_W'(i))
                    tbl[i] <= wdata;
            end
        end
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_vmask
        assign vmask[g] = tbl[g].valid;
    end

    // R1: reset leaves no valid entry
    p_reset_clears_r1: assert property (@(posedge clk) rst |=> (vmask == '0));
    // R10: user-mode write does not touch the table
    p_user_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (we && !kernel) |=> $stable(tbl));
    // R10: denial flag follows a user-mode attempt
    p_denied_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (we && !kernel) |=> denied);
endmodule

// File: rtl/seg_check.sv
module seg_check
    import segxlat_pkg::*;
(
    input  seg_entry_t [NSEG-1:0] tbl,
    input  logic [VA_W-1:0]       va,
    input  logic                  wr,
    output xlat_res_t             res
);
    seg_entry_t       ent;
    logic [OFF_W-1:0] off;
    fault_e           flt;

    always_comb begin
        ent       = tbl[va[VA_W-1 -: SEG_W]];
        off       = va[OFF_W-1:0];
        flt       = judge(ent, off, wr);
        res.fault = flt;
        res.pa    = (flt == FLT_NONE) ? relocate(ent.base, off) : '0;
    end
endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
    import segxlat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  xlat_res_t       res,
    output logic            rsp_valid,
    output fault_e          rsp_fault,
    output logic [PA_W-1:0] rsp_pa
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid ? res.fault : FLT_NONE;
            rsp_pa    <= req_valid ? res.pa : '0;
        end
    end

    // R7: faulting response carries no address
    p_fault_pa_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0));
endmodule

// File: rtl/segxlat_top.sv
module segxlat_top
    import segxlat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic                  cfg_kernel,
    input  logic [SEG_W-1:0]      cfg_idx,
    input  logic [PA_W-1:0]       cfg_base,
    input  logic [OFF_W-1:0]      cfg_limit,
    input  logic                  cfg_valid,
    input  logic                  cfg_writable,
    output logic                  cfg_denied,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_va,
    input  logic                  req_write,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_pa,
    output logic [1:0]            rsp_fault
);
    seg_entry_t            wdata;
    seg_entry_t [NSEG-1:0] tbl;
    xlat_res_t             res;
    fault_e                fault_q;
    seg_entry_t            req_ent;

    assign wdata = '{base: cfg_base, limit: cfg_limit, valid: cfg_valid, writable: cfg_writable};

    seg_table u_table (
        .clk(clk), .rst(rst), .we(cfg_we), .kernel(cfg_kernel), .idx(cfg_idx),
        .wdata(wdata), .tbl(tbl), .denied(cfg_denied)
    );

    seg_check u_check (.tbl(tbl), .va(req_va), .wr(req_write), .res(res));

    seg_resp_reg u_resp (
        .clk(clk), .rst(rst), .req_valid(req_valid), .res(res),
        .rsp_valid(rsp_valid), .rsp_fault(fault_q), .rsp_pa(rsp_pa)
    );

    assign rsp_fault = fault_q;
    assign req_ent   = tbl[req_va[VA_W-1 -: SEG_W]];

    // R8: one-cycle latency, strobe only after a request
    p_latency_r8: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid);
    p_idle_r8:    assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid);
    // R5: in-range store to a read-only valid segment reports protection fault
    p_ro_store_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_ent.valid && !req_ent.writable &&
         req_va[OFF_W-1:0] <= req_ent.limit) |=> (rsp_fault == 2'b11));
endmodule

// File: tb/sim_segxlat_top.sv
module sim_segxlat_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0, cfg_kernel = 0, cfg_valid = 0, cfg_writable = 0;
    logic [1:0]  cfg_idx = 0;
    logic [15:0] cfg_base = 0;
    logic [13:0] cfg_limit = 0;
    logic        cfg_denied;
    logic        req_valid = 0, req_write = 0;
    logic [15:0] req_va = 0;
    logic        rsp_valid;
    logic [15:0] rsp_pa;
    logic [1:0]  rsp_fault;

    always #2 clk = ~clk;

    segxlat_top u0 (.*);

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_base [4];
    logic [13:0] m_lim  [4];
    logic        m_v    [4];
    logic        m_w    [4];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(logic [15:0] va, logic wr);
        logic [1:0]  s = va[15:14];
        logic [13:0] o = va[13:0];
        if (!m_v[s])            return 2'b01;
        else if (o > m_lim[s])  return 2'b10;
        else if (wr && !m_w[s]) return 2'b11;
        return 2'b00;
    endfunction

    function automatic logic [15:0] exp_pa(logic [15:0] va, logic wr);
        if (exp_fault(va, wr) != 2'b00) return 16'h0;
        return m_base[va[15:14]] + {2'b00, va[13:0]};
    endfunction

    task automatic access(logic [15:0] va, logic wr, string req);
        logic [1:0]  ef;
        logic [15:0] ep;
        @(negedge clk);
        req_valid = 1; req_va = va; req_write = wr;
        ef = exp_fault(va, wr);
        ep = exp_pa(va, wr);
        @(negedge clk);
        req_valid = 0;
        chk(req, "rsp_valid", rsp_valid, 1);
        chk(req, "rsp_fault", rsp_fault, ef);
        chk(req, "rsp_pa", rsp_pa, ep);
    endtask

    task automatic kwrite(logic [1:0] idx, logic [15:0] b, logic [13:0] l,
                          logic v, logic w, logic kern);
        @(negedge clk);
        cfg_we = 1; cfg_kernel = kern; cfg_idx = idx; cfg_base = b;
        cfg_limit = l; cfg_valid = v; cfg_writable = w;
        @(negedge clk);
        cfg_we = 0;
        chk("R10", "cfg_denied", cfg_denied, !kern);
        if (kern) begin
            m_base[idx] = b; m_lim[idx] = l; m_v[idx] = v; m_w[idx] = w;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd2024);
        for (int i = 0; i < 4; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_v[i] = 0; m_w[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "cfg_denied", cfg_denied, 0);
        for (int s = 0; s < 4; s++) access({s[1:0], 14'h0}, 0, "R1");

        // Directed: code RO segment 0, data RW segment 1
        kwrite(2'd0, 16'h4000, 14'h03FF, 1, 0, 1);
        kwrite(2'd1, 16'h4800, 14'h03FF, 1, 1, 1);
        access(16'h0240, 0, "R2");
        access(16'h4050, 0, "R2");
        access(16'h4050, 1, "R5");
        access(16'h43FF, 0, "R3");
        access(16'h4400, 0, "R3");
        access(16'h0100, 1, "R5");
        access(16'h0400, 1, "R6");
        access(16'h8FFF, 1, "R4");
        access(16'hBFFF, 1, "R6");
        // R8: strobe drops with no request
        @(negedge clk);
        chk("R8", "rsp_valid idle", rsp_valid, 0);
        chk("R7", "rsp_pa idle", rsp_pa, 0);

        // R9: same-cycle write and request sees old entry
        @(negedge clk);
        cfg_we = 1; cfg_kernel = 1; cfg_idx = 2'd3; cfg_base = 16'hFFF0;
        cfg_limit = 14'h3FFF; cfg_valid = 1; cfg_writable = 1;
        req_valid = 1; req_va = 16'hC020; req_write = 0;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        chk("R9", "same-cycle fault", rsp_fault, 2'b01);
        chk("R9", "same-cycle pa", rsp_pa, 0);
        m_base[3] = 16'hFFF0; m_lim[3] = 14'h3FFF; m_v[3] = 1; m_w[3] = 1;
        access(16'hC020, 0, "R9");
        chk("R2", "wrap", rsp_pa, 16'h0010);

        // R10: user write ignored
        kwrite(2'd1, 16'h1234, 14'h0001, 0, 0, 0);
        access(16'h4050, 1, "R10");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int unsigned r = $urandom % 8;
            if (r == 0) begin
                kwrite(2'($urandom), 16'($urandom), 14'($urandom), ($urandom % 4) != 0,
                       1'($urandom), ($urandom % 5) != 0);
            end else if (r == 1) begin
                logic [1:0] s = 2'($urandom);
                access({s, m_lim[s] + 14'(($urandom % 3))}, 1'($urandom), "R3");
            end else begin
                access(16'($urandom), 1'($urandom), "R6");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule